// File: doc/BRIEF.md
# Lower-Half Write-Protection Guard

This block keeps the software write-protection state of a 256-byte serial memory and makes every acknowledge decision that depends on it. A bit-level bus sequencer hands it the select byte of the current instruction, the position of the byte being acknowledged, the target address, the chip-enable pin levels, a flag for an elevated voltage on chip enable 0 and the write-control pin. The guard answers with an ACK/NoAck decision for that byte, tells the sequencer whether a STOP after this byte would launch a self-timed write cycle, and gives a write-allow for the addressed location.

The state has three levels: open, soft-protected (lower half read-only, reversible) and locked (lower half read-only for good, and the protection identifier stops answering). Three protection instructions move between them: set, clear and permanent set. A change takes effect only when the sequencer reports that the write cycle has completed. The state register has no reset, so that it behaves like the nonvolatile cell it stands for. A back-door preload port lets a bench model a power cycle.

Top module: `lowhalf_guard`

## Requirements
- R1: Select byte fields are bits 7..4 device type, bits 3..1 chip bits and bit 0 direction (1 = read). `byte_pos` is 0 for the select byte, 1 for the address byte and 2 or more for a data byte. A memory-type select (type 1010) is acknowledged only when its chip bits equal `ce_pins` {E2,E1,E0}. Its address byte is acknowledged for a write. The address and data positions of a read are never acknowledged.
- R2: With type 0110 and `hv_ce0` high, chip bits 001 with E2=E1=0 decode as set, and chip bits 011 with E2=0, E1=1 decode as clear. With `hv_ce0` low, chip bits equal to `ce_pins` decode as permanent set. Any other 0110 select gets NoAck on every byte.
- R3: In the open state (`prot_state` 00) all three protection writes acknowledge select and address. With `wr_ctrl` low the data byte is acknowledged and `wr_trig` is 1. With `wr_ctrl` high the data byte gets NoAck and `wr_trig` is 0. `wr_trig` is never 1 without `ack`.
- R4: In the soft state (01) every byte of a set instruction gets NoAck. Clear and permanent set behave as in R3.
- R5: In the locked state (11) every byte of every 0110-type instruction gets NoAck, read or write, whatever `wr_ctrl` is. No instruction, cycle completion or reset leaves the locked state.
- R6: A protection instruction with bit 0 = 1 acknowledges the select byte exactly when the same write instruction would. Its address and data positions always get NoAck, and `wr_trig` stays 0.
- R7: `wr_allow` is 0 for every address while `wr_ctrl` is high. With `wr_ctrl` low, addresses 80h..FFh are allowed, and 00h..7Fh are allowed only in the open state. A memory write data byte is acknowledged, and `wr_trig` raised, exactly when `wr_allow` is 1.
- R8: `prot_state` changes only on a `cyc_done` pulse that follows an acknowledged protection data byte, or through preload. Set gives 01, clear gives 00 and permanent set gives 11.
- R9: A new select strobe before `cyc_done` discards the pending change. A `cyc_done` with nothing pending leaves the state as it was.
- R10: Reset does not alter `prot_state`. A `pre_en` cycle loads `pre_state` (10 loads as 01), and `perm_lock` is 1 exactly in state 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (clears only the pending change) |
| byte_stb | input | 1 | A byte at `byte_pos` has been received this cycle |
| sel_byte | input | 8 | Select byte of the current instruction |
| hv_ce0 | input | 1 | Elevated voltage detected on chip enable 0 |
| ce_pins | input | 3 | Chip-enable logic levels {E2,E1,E0} |
| wr_ctrl | input | 1 | Write-control pin, high blocks writes |
| byte_pos | input | POS_W (2) | Byte position within the instruction |
| tgt_addr | input | AW (8) | Target memory address |
| cyc_done | input | 1 | Self-timed write cycle completed |
| pre_en | input | 1 | Back-door preload strobe |
| pre_state | input | 2 | Back-door preload value |
| ack | output | 1 | ACK decision for the current byte |
| wr_trig | output | 1 | A STOP after this byte would start a write cycle |
| wr_allow | output | 1 | `tgt_addr` may be written |
| prot_state | output | 2 | 00 open, 01 soft, 11 locked |
| perm_lock | output | 1 | Permanent lock in force |

## Verification
The bench builds the guard with AW=8, POS_W=2 and strict pin checking on set and clear. These values make both 128-byte halves reachable and let a fourth byte position model a page write. They also expose the overlap between permanent set and set, both of which use chip bits 001 on pins 001 and are told apart only by the voltage flag. Random instructions are drawn over every pin, voltage, write-control and direction pattern, with periodic preloads into each state. Directed sequences cover aborts, lock retention across reset and the soft-state refusal of set.

// File: rtl/lhg_pkg.sv
package lhg_pkg;

   typedef enum logic [1:0] {
      PS_OPEN = 2'b00,
      PS_SOFT = 2'b01,
      PS_LOCK = 2'b11
   } prot_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_MEM  = 3'd1,
      OP_SET  = 3'd2,
      OP_CLR  = 3'd3,
      OP_PERM = 3'd4
   } op_e;

   typedef struct packed {
      logic [3:0] dtype;
      logic [2:0] chip;
      logic       rd;
   } sel_t;

   function automatic prot_e norm_state(input logic [1:0] v);
      case (v)
         2'b00:   return PS_OPEN;
         2'b11:   return PS_LOCK;
         default: return PS_SOFT;
      endcase
   endfunction

   function automatic logic is_prot_op(input op_e op);
      return (op == OP_SET) || (op == OP_CLR) || (op == OP_PERM);
   endfunction

endpackage

// File: rtl/lhg_decode.sv
module lhg_decode
   import lhg_pkg::*;
#(
   parameter logic [3:0] MEM_ID      = 4'b1010,
   parameter logic [3:0] PROT_ID     = 4'b0110,
   parameter bit         STRICT_PINS = 1'b1
) (
   input  logic [7:0] sel_byte,
   input  logic       hv_ce0,
   input  logic [2:0] ce_pins,
   output op_e        op,
   output logic       rd
);

   localparam logic [2:0] SET_CHIP = 3'b001;
   localparam logic [2:0] CLR_CHIP = 3'b011;

   sel_t sel;
   logic set_pins_ok;
   logic clr_pins_ok;

   assign sel = sel_t'(sel_byte);
   assign rd  = sel.rd;

   generate
      if (STRICT_PINS) begin : g_strict
         assign set_pins_ok = (ce_pins[2:1] == 2'b00);
         assign clr_pins_ok = (ce_pins[2:1] == 2'b01);
      end else begin : g_loose
         assign set_pins_ok = 1'b1;
         assign clr_pins_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      op = OP_NONE;
      if ((sel.dtype == MEM_ID) && (sel.chip == ce_pins)) begin
         op = OP_MEM;
      end else if (sel.dtype == PROT_ID) begin
         if (hv_ce0) begin
            if ((sel.chip == SET_CHIP) && set_pins_ok)
               op = OP_SET;
            else if ((sel.chip == CLR_CHIP) && clr_pins_ok)
               op = OP_CLR;
         end else if (sel.chip == ce_pins) begin
            op = OP_PERM;
         end
      end
   end

endmodule

// File: rtl/lhg_respond.sv
module lhg_respond
   import lhg_pkg::*;
#(
   parameter int AW    = 8,
   parameter int POS_W = 2
) (
   input  op_e              op,
   input  logic             rd,
   input  logic [POS_W-1:0] byte_pos,
   input  logic [AW-1:0]    tgt_addr,
   input  logic             wr_ctrl,
   input  prot_e            state,
   output logic             ack,
   output logic             wr_trig,
   output logic             wr_allow
);

   localparam logic [AW-1:0]    LOW_SPAN = AW'(1) << (AW - 1);
   localparam logic [POS_W-1:0] POS_SEL  = '0;
   localparam logic [POS_W-1:0] POS_ADR  = POS_W'(1);
   localparam logic [POS_W-1:0] POS_DAT  = POS_W'(2);

   logic in_low;
   logic sel_ok;
   logic at_sel;
   logic at_adr;

   assign in_low   = (tgt_addr < LOW_SPAN);
   assign wr_allow = !wr_ctrl && (!in_low || (state == PS_OPEN));
   assign at_sel   = (byte_pos == POS_SEL);
   assign at_adr   = (byte_pos == POS_ADR);

   assign sel_ok = is_prot_op(op) && (state != PS_LOCK) &&
                   !((state == PS_SOFT) && (op == OP_SET));

   always_comb begin
      ack     = 1'b0;
      wr_trig = 1'b0;
      if (op == OP_MEM) begin
         if (at_sel) begin
            ack = 1'b1;
         end else if (!rd) begin
            if (at_adr) begin
               ack = 1'b1;
            end else if (byte_pos >= POS_DAT) begin
               ack     = wr_allow;
               wr_trig = wr_allow;
            end
         end
      end else if (is_prot_op(op)) begin
         if (at_sel) begin
            ack = sel_ok;
         end else if (!rd) begin
            if (at_adr) begin
               ack = sel_ok;
            end else if (byte_pos >= POS_DAT) begin
               ack     = sel_ok && !wr_ctrl;
               wr_trig = sel_ok && !wr_ctrl;
            end
         end
      end
   end

endmodule

// File: rtl/lhg_store.sv
module lhg_store
   import lhg_pkg::*;
#(
   parameter int POS_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic [POS_W-1:0] byte_pos,
   input  op_e              op,
   input  logic             wr_trig,
   input  logic             cyc_done,
   input  logic             pre_en,
   input  logic [1:0]       pre_state,
   output prot_e            state
);

   localparam logic [POS_W-1:0] POS_DAT = POS_W'(2);

   prot_e state_q;
   logic  pend_q;
   op_e   pend_op_q;
   logic  arm;
   logic  drop;

   assign arm  = byte_stb && (byte_pos >= POS_DAT) && is_prot_op(op) && wr_trig;
   assign drop = byte_stb && (byte_pos == '0);

   function automatic prot_e next_state(input prot_e cur, input op_e pop);
      if (cur == PS_LOCK) return PS_LOCK;
      case (pop)
         OP_SET:  return PS_SOFT;
         OP_CLR:  return PS_OPEN;
         OP_PERM: return PS_LOCK;
         default: return cur;
      endcase
   endfunction

   // Retained state: deliberately outside the reset domain.
   always_ff @(posedge clk) begin
      if (pre_en)
         state_q <= norm_state(pre_state);
      else if (cyc_done && pend_q)
         state_q <= next_state(state_q, pend_op_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_op_q <= OP_NONE;
      end else if (cyc_done) begin
         pend_q    <= 1'b0;
      end else if (drop) begin
         pend_q    <= 1'b0;
      end else if (arm) begin
         pend_q    <= 1'b1;
         pend_op_q <= op;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/lowhalf_guard.sv
module lowhalf_guard
   import lhg_pkg::*;
#(
   parameter int         AW          = 8,
   parameter int         POS_W       = 2,
   parameter logic [3:0] MEM_ID      = 4'b1010,
   parameter logic [3:0] PROT_ID     = 4'b0110,
   parameter bit         STRICT_PINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic [7:0]       sel_byte,
   input  logic             hv_ce0,
   input  logic [2:0]       ce_pins,
   input  logic             wr_ctrl,
   input  logic [POS_W-1:0] byte_pos,
   input  logic [AW-1:0]    tgt_addr,
   input  logic             cyc_done,
   input  logic             pre_en,
   input  logic [1:0]       pre_state,
   output logic             ack,
   output logic             wr_trig,
   output logic             wr_allow,
   output logic [1:0]       prot_state,
   output logic             perm_lock
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("lowhalf_guard: AW must be at least 2");
      end
      if (POS_W < 2) begin : g_bad_pos
         $error("lowhalf_guard: POS_W must be at least 2");
      end
      if (MEM_ID == PROT_ID) begin : g_bad_id
         $error("lowhalf_guard: MEM_ID and PROT_ID must differ");
      end
   endgenerate

   op_e   op;
   logic  rd;
   prot_e state;

   lhg_decode #(
      .MEM_ID      (MEM_ID),
      .PROT_ID     (PROT_ID),
      .STRICT_PINS (STRICT_PINS)
   ) u_decode (
      .sel_byte (sel_byte),
      .hv_ce0   (hv_ce0),
      .ce_pins  (ce_pins),
      .op       (op),
      .rd       (rd)
   );

   lhg_respond #(
      .AW    (AW),
      .POS_W (POS_W)
   ) u_respond (
      .op       (op),
      .rd       (rd),
      .byte_pos (byte_pos),
      .tgt_addr (tgt_addr),
      .wr_ctrl  (wr_ctrl),
      .state    (state),
      .ack      (ack),
      .wr_trig  (wr_trig),
      .wr_allow (wr_allow)
   );

   lhg_store #(
      .POS_W (POS_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_stb  (byte_stb),
      .byte_pos  (byte_pos),
      .op        (op),
      .wr_trig   (wr_trig),
      .cyc_done  (cyc_done),
      .pre_en    (pre_en),
      .pre_state (pre_state),
      .state     (state)
   );

   assign prot_state = state;
   assign perm_lock  = (state == PS_LOCK);

endmodule

// File: rtl/lhg_chk.sv
module lhg_chk #(
   parameter int         POS_W   = 2,
   parameter logic [3:0] PROT_ID = 4'b0110
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       sel_byte,
   input logic             hv_ce0,
   input logic [POS_W-1:0] byte_pos,
   input logic             wr_ctrl,
   input logic             cyc_done,
   input logic             pre_en,
   input logic             ack,
   input logic             wr_trig,
   input logic             wr_allow,
   input logic [1:0]       prot_state,
   input logic             perm_lock
);

   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_lock && !pre_en) |=> perm_lock);

   assert_lock_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (perm_lock && (sel_byte[7:4] == PROT_ID)) |-> !ack);

   assert_soft_refuses_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((prot_state == 2'b01) && (sel_byte[7:1] == {PROT_ID, 3'b001}) && hv_ce0 &&
       (byte_pos == '0)) |-> !ack);

   assert_trig_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_trig |-> ack);

   assert_read_phase_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_byte[7:4] == PROT_ID) && sel_byte[0] && (byte_pos != '0)) |-> (!ack && !wr_trig));

   assert_wc_blocks_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |-> !wr_allow);

   assert_commit_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_done && !pre_en) |=> $stable(prot_state));

endmodule

bind lowhalf_guard lhg_chk #(
   .POS_W   (POS_W),
   .PROT_ID (PROT_ID)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_byte   (sel_byte),
   .hv_ce0     (hv_ce0),
   .byte_pos   (byte_pos),
   .wr_ctrl    (wr_ctrl),
   .cyc_done   (cyc_done),
   .pre_en     (pre_en),
   .ack        (ack),
   .wr_trig    (wr_trig),
   .wr_allow   (wr_allow),
   .prot_state (prot_state),
   .perm_lock  (perm_lock)
);

// File: tb/lowhalf_guard_test.sv
module lowhalf_guard_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       byte_stb;
   logic [7:0] sel_byte;
   logic       hv_ce0;
   logic [2:0] ce_pins;
   logic       wr_ctrl;
   logic [1:0] byte_pos;
   logic [7:0] tgt_addr;
   logic       cyc_done;
   logic       pre_en;
   logic [1:0] pre_state;
   logic       ack;
   logic       wr_trig;
   logic       wr_allow;
   logic [1:0] prot_state;
   logic       perm_lock;

   int  n_chk = 0;
   int  n_err = 0;
   bit  ended = 1'b0;

   // Reference model state
   logic [1:0] ms = 2'b00;
   bit         mpend = 1'b0;
   int         mop = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lowhalf_guard uut (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .sel_byte(sel_byte),
      .hv_ce0(hv_ce0), .ce_pins(ce_pins), .wr_ctrl(wr_ctrl), .byte_pos(byte_pos),
      .tgt_addr(tgt_addr), .cyc_done(cyc_done), .pre_en(pre_en), .pre_state(pre_state),
      .ack(ack), .wr_trig(wr_trig), .wr_allow(wr_allow), .prot_state(prot_state),
      .perm_lock(perm_lock)
   );

   // 0 none, 1 memory, 2 set, 3 clear, 4 permanent set
   function automatic int f_op(logic [7:0] s, logic hv, logic [2:0] p);
      if (s[7:4] == 4'b1010 && s[3:1] == p) return 1;
      if (s[7:4] == 4'b0110) begin
         if (hv) begin
            if (s[3:1] == 3'b001 && p[2:1] == 2'b00) return 2;
            if (s[3:1] == 3'b011 && p[2:1] == 2'b01) return 3;
         end else if (s[3:1] == p) return 4;
      end
      return 0;
   endfunction

   function automatic bit f_allow(logic wc, logic [1:0] st, logic [7:0] a);
      return !wc && (a >= 8'h80 || st == 2'b00);
   endfunction

   function automatic bit f_selok(int op, logic [1:0] st);
      if (op < 2) return 1'b0;
      if (st == 2'b11) return 1'b0;
      if (st == 2'b01 && op == 2) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit f_ack(int op, bit rd, int pos, logic wc, logic [1:0] st, logic [7:0] a);
      if (op == 1) begin
         if (pos == 0) return 1'b1;
         if (rd) return 1'b0;
         if (pos == 1) return 1'b1;
         return f_allow(wc, st, a);
      end
      if (op >= 2) begin
         if (pos == 0) return f_selok(op, st);
         if (rd) return 1'b0;
         if (pos == 1) return f_selok(op, st);
         return f_selok(op, st) && !wc;
      end
      return 1'b0;
   endfunction

   function automatic bit f_trig(int op, bit rd, int pos, logic wc, logic [1:0] st, logic [7:0] a);
      if (rd || pos < 2) return 1'b0;
      if (op == 1) return f_allow(wc, st, a);
      if (op >= 2) return f_selok(op, st) && !wc;
      return 1'b0;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      byte_stb = 1'b0; cyc_done = 1'b0; pre_en = 1'b0;
   endtask

   // One byte presented for one clock; outputs checked before the edge.
   task automatic put(string tag, logic [7:0] s, int pos, logic [7:0] a, bit stb);
      int  op;
      bit  ea, et;
      @(negedge clk);
      idle_inputs();
      sel_byte = s; byte_pos = 2'(pos); tgt_addr = a; byte_stb = stb;
      #1;
      op = f_op(s, hv_ce0, ce_pins);
      ea = f_ack(op, s[0], pos, wr_ctrl, ms, a);
      et = f_trig(op, s[0], pos, wr_ctrl, ms, a);
      check({tag, " ack"}, 8'(ack), 8'(ea));
      check({tag, " trig"}, 8'(wr_trig), 8'(et));
      check("R7 allow", 8'(wr_allow), 8'(f_allow(wr_ctrl, ms, a)));
      check("R8 state", 8'(prot_state), 8'(ms));
      check("R10 lockflag", 8'(perm_lock), 8'(ms == 2'b11));
      if (stb) begin
         if (pos == 0) mpend = 1'b0;
         else if (pos >= 2 && op >= 2 && et) begin mpend = 1'b1; mop = op; end
      end
   endtask

   task automatic done_cyc();
      @(negedge clk);
      idle_inputs();
      cyc_done = 1'b1;
      if (mpend && ms != 2'b11) begin
         if (mop == 2) ms = 2'b01;
         else if (mop == 3) ms = 2'b00;
         else if (mop == 4) ms = 2'b11;
      end
      mpend = 1'b0;
   endtask

   task automatic preload(logic [1:0] v);
      @(negedge clk);
      idle_inputs();
      pre_en = 1'b1; pre_state = v;
      ms = (v == 2'b10) ? 2'b01 : v;
   endtask

   task automatic chk_state(string tag, logic [1:0] exp);
      @(negedge clk);
      idle_inputs();
      #1;
      check(tag, 8'(prot_state), 8'(exp));
      check({tag, " lockflag"}, 8'(perm_lock), 8'(exp == 2'b11));
   endtask

   task automatic full_instr(string tag, logic [7:0] s, logic [7:0] a);
      put(tag, s, 0, a, 1'b1);
      put(tag, s, 1, a, 1'b1);
      put(tag, s, 2, a, 1'b1);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] seed_val;
      seed_val = $urandom(32'd2024);
      rst_n = 1'b0; idle_inputs();
      sel_byte = '0; hv_ce0 = 0; ce_pins = '0; wr_ctrl = 0; byte_pos = '0;
      tgt_addr = '0; pre_state = '0;

      // R10: preload during reset survives reset release
      preload(2'b01);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_state("R10 after reset", 2'b01);

      // R4: soft state refuses set
      hv_ce0 = 1; ce_pins = 3'b000; wr_ctrl = 0;
      full_instr("R4 soft set", 8'b0110_0010, 8'h00);
      done_cyc();
      chk_state("R4 soft set no change", 2'b01);

      // R4/R3: clear with write control high: data NoAck, no change
      ce_pins = 3'b010; wr_ctrl = 1;
      full_instr("R4 clear wc high", 8'b0110_0110, 8'h11);
      done_cyc();
      chk_state("R3 wc high no change", 2'b01);

      // R8: clear with write control low commits to open
      wr_ctrl = 0;
      full_instr("R4 clear", 8'b0110_0110, 8'h22);
      done_cyc();
      chk_state("R8 clear commit", 2'b00);

      // R9: abort by new select before cycle completes
      ce_pins = 3'b000;
      full_instr("R3 open set", 8'b0110_0010, 8'h00);
      hv_ce0 = 0;
      put("R1 mem read sel", 8'b1010_0001, 0, 8'h00, 1'b1);
      done_cyc();
      chk_state("R9 abort keeps open", 2'b00);
      done_cyc();
      chk_state("R9 stray done", 2'b00);

      // R8: set commits to soft
      hv_ce0 = 1;
      full_instr("R3 open set", 8'b0110_0010, 8'h00);
      done_cyc();
      chk_state("R8 set commit", 2'b01);

      // R7: address halves
      hv_ce0 = 0; ce_pins = 3'b000; wr_ctrl = 0;
      put("R7 low soft", 8'b1010_0000, 2, 8'h7F, 1'b0);
      put("R7 high soft", 8'b1010_0000, 2, 8'h80, 1'b0);
      wr_ctrl = 1;
      put("R7 high wc", 8'b1010_0000, 2, 8'hFF, 1'b0);
      wr_ctrl = 0;
      preload(2'b00);
      put("R7 low open", 8'b1010_0000, 2, 8'h00, 1'b0);

      // R2/R1: unrecognised selects
      hv_ce0 = 1; ce_pins = 3'b101;
      put("R2 bad hv chip", 8'b0110_1010, 0, 8'h00, 1'b0);
      hv_ce0 = 0;
      put("R2 perm mismatch", 8'b0110_1000, 0, 8'h00, 1'b0);
      put("R1 mem mismatch", 8'b1010_0000, 0, 8'h00, 1'b0);
      put("R1 mem read addr", 8'b1010_1011, 1, 8'h00, 1'b0);

      // R6: read-form protection instruction
      hv_ce0 = 1; ce_pins = 3'b010;
      put("R6 read clear sel", 8'b0110_0111, 0, 8'h00, 1'b0);
      put("R6 read clear adr", 8'b0110_0111, 1, 8'h00, 1'b0);
      put("R6 read clear dat", 8'b0110_0111, 2, 8'h00, 1'b0);

      // R5: permanent lock
      hv_ce0 = 0; ce_pins = 3'b101;
      full_instr("R3 open perm", 8'b0110_1010, 8'h40);
      done_cyc();
      chk_state("R8 perm commit", 2'b11);
      put("R5 perm again", 8'b0110_1010, 0, 8'h00, 1'b0);
      put("R5 read perm", 8'b0110_1011, 0, 8'h00, 1'b0);
      hv_ce0 = 1; ce_pins = 3'b010;
      put("R5 clear muted", 8'b0110_0110, 0, 8'h00, 1'b1);
      done_cyc();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk_state("R5 lock survives reset", 2'b11);
      put("R10 sanity", 8'b0110_0111, 0, 8'h00, 1'b0);

      // Random traffic
      for (int it = 0; it < 1500; it++) begin
         logic [7:0] s, a;
         int kind;
         if (it % 60 == 0) begin
            int pick = $urandom_range(0, 3);
            preload(pick == 3 ? 2'b11 : (pick == 2 ? 2'b10 : 2'(pick)));
         end
         hv_ce0  = $urandom_range(0, 1);
         ce_pins = 3'($urandom_range(0, 7));
         wr_ctrl = ($urandom_range(0, 3) == 0);
         kind = $urandom_range(0, 3);
         s = 8'($urandom());
         if (kind == 0) s[7:4] = 4'b1010;
         else if (kind >= 1) s[7:4] = (kind == 3) ? s[7:4] : 4'b0110;
         if ($urandom_range(0, 1) == 1) s[3:1] = ce_pins;
         else if (hv_ce0) s[3:1] = ($urandom_range(0, 1) == 1) ? 3'b001 : 3'b011;
         a = 8'($urandom());
         put("R3 rnd sel", s, 0, a, 1'b1);
         put("R6 rnd adr", s, 1, a, 1'b1);
         put("R7 rnd dat", s, 2, a, 1'b1);
         if ($urandom_range(0, 3) == 0) put("R7 rnd page", s, 3, a + 8'd1, 1'b1);
         if ($urandom_range(0, 2) != 0) done_cyc();
      end

      chk_state("R8 final", ms);
      finish_run();
   end

endmodule